// File: doc/BRIEF.md
# Prioritised External Interrupt Controller

This block gathers level-sensitive interrupt requests from up to 31 sources (IDs 1 to 31) and sends one external-interrupt line to a single hart context. Each source has a 3-bit priority. The hart context has an enable bitmap and a priority threshold. The controller drives the interrupt line whenever some pending, enabled source has a priority strictly above the threshold.

Software uses a simple register bus. Reading the claim register returns the best eligible source ID and takes that source out of the pending set. The source then stays blocked until software writes the same ID back to the same register. ID 0 is reserved and means "nothing to claim".

Each source has its own gateway state machine with three states:
- `GW_IDLE` means nothing is latched.
- `GW_PEND` means the request has been latched and is waiting.
- `GW_BUSY` means the source has been claimed and is being serviced.

Its transitions are:
- *arm*: `GW_IDLE` to `GW_PEND`, taken while the request is high.
- *claim*: `GW_PEND` to `GW_BUSY`, taken when a claim read selects this ID.
- *complete*: `GW_BUSY` to `GW_IDLE`, taken on a complete write that names this ID.

Top module: `irq_hub`

## Requirements
- R1: After reset, every priority is 0, the enable bitmap is 0, the threshold is 0, nothing is pending and `ext_irq` is low.
- R2: A high request on an idle source sets its pending bit after the next clock edge. The pending bitmap is read at offset 0x001000, with bit k standing for ID k. The bit stays set after the request drops, until the source is claimed.
- R3: `ext_irq` is high, combinationally, exactly when some source is pending, has its enable bit set and has a priority above the threshold. The enable bitmap is at offset 0x002000, with bit k standing for ID k.
- R4: Delivery needs a priority strictly greater than the threshold register at offset 0x200000. A priority equal to the threshold, or a priority of 0, is never delivered.
- R5: A read of offset 0x200004 returns the eligible ID with the highest priority, and the lowest ID wins a tie. Read data appears on `bus_rdata` in the cycle after the read strobe.
- R6: A claim clears the chosen pending bit. That source cannot pend again while it is claimed, even if its request stays high.
- R7: Writing an in-flight ID to offset 0x200004 releases that source, which pends again one cycle later if its request is still high. A complete write naming a source that is not in flight changes nothing.
- R8: A claim read with no eligible source returns 0 and changes no state.
- R9: Writes to the pending bitmap have no effect. Reads of unmapped offsets, and of the ID 0 priority word, return 0.
- R10: Priority words sit at offset 4*ID, store the low 3 bits and read back with the upper bits at zero. The enable and threshold registers read back what was written, except that enable bit 0 always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_req | input | 31 | Level requests, bit k is source ID k (range [31:1]) |
| bus_addr | input | 24 | Byte offset of the register access |
| bus_rd | input | 1 | Read strobe, one cycle |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data, valid the cycle after `bus_rd` |
| ext_irq | output | 1 | External-interrupt request to the hart |

## Verification
The assertions check the following on every cycle:
- a pending bit only appears from a request;
- a pending bit never appears on a source that was busy;
- a claim moves the winner into the busy set;
- a busy source is released only by a complete write;
- an empty claim returns 0.

Other behaviour only the bench scenarios can show:
- which ID wins a claim when priorities tie;
- that the threshold comparison is strict;
- that stray writes leave state unchanged;
- the exact register readback values.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;
    localparam logic [31:0] OFF_PEND  = 32'h0000_1000;
    localparam logic [31:0] OFF_EN    = 32'h0000_2000;
    localparam logic [31:0] OFF_THR   = 32'h0020_0000;
    localparam logic [31:0] OFF_CLAIM = 32'h0020_0004;

    typedef enum logic [1:0] {
        GW_IDLE = 2'd0,
        GW_PEND = 2'd1,
        GW_BUSY = 2'd2
    } gw_state_t;
endpackage

// File: rtl/irq_gateway.sv
module irq_gateway
    import irq_hub_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic claim,
    input  logic complete,
    output logic pending,
    output logic busy
);
    gw_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GW_IDLE: if (req)      state_d = GW_PEND;
            GW_PEND: if (claim)    state_d = GW_BUSY;
            GW_BUSY: if (complete) state_d = GW_IDLE;
            default:               state_d = GW_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= GW_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        pending = 1'b0;
        busy    = 1'b0;
        unique case (state_q)
            GW_IDLE: ;
            GW_PEND: pending = 1'b1;
            GW_BUSY: busy    = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
    parameter int NSRC   = 31,
    parameter int PRIO_W = 3,
    parameter int ID_W   = 5
) (
    input  logic [NSRC:1]             cand,
    input  logic [NSRC:1][PRIO_W-1:0] prio,
    input  logic [PRIO_W-1:0]         thr,
    output logic [ID_W-1:0]           win_id,
    output logic                      any
);
    logic [PRIO_W-1:0] best;

    // Seeding with the threshold makes the test strict; scanning upward with
    // a strict compare keeps the lowest ID on a tie.
    always_comb begin
        best   = thr;
        win_id = '0;
        for (int k = 1; k <= NSRC; k++) begin
            if (cand[k] && (prio[k] > best)) begin
                best   = prio[k];
                win_id = ID_W'(k);
            end
        end
        any = (win_id != '0);
    end
endmodule

// File: rtl/irq_hub.sv
module irq_hub
    import irq_hub_pkg::*;
#(
    parameter int NSRC   = 31,
    parameter int PRIO_W = 3,
    parameter int ADDR_W = 24,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC:1]     src_req,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              ext_irq
);
    localparam int ID_W = $clog2(NSRC + 1);

    logic [NSRC:1][PRIO_W-1:0] prio_q;
    logic [NSRC:1]             en_q;
    logic [PRIO_W-1:0]         thr_q;
    logic [NSRC:1]             pend_vec, busy_vec, claim_vec, cmpl_vec;
    logic [ID_W-1:0]           arb_id;
    logic                      arb_any;
    logic [DATA_W-1:0]         rd_val;

    wire in_prio   = (bus_addr[ADDR_W-1:12] == '0) && (bus_addr[1:0] == 2'b00);
    wire [9:0] pix = bus_addr[11:2];
    wire at_pend   = (bus_addr == OFF_PEND[ADDR_W-1:0]);
    wire at_en     = (bus_addr == OFF_EN[ADDR_W-1:0]);
    wire at_thr    = (bus_addr == OFF_THR[ADDR_W-1:0]);
    wire at_claim  = (bus_addr == OFF_CLAIM[ADDR_W-1:0]);
    wire claim_go  = bus_rd && at_claim;
    wire cmpl_go   = bus_wr && at_claim;

    generate
        for (genvar g = 1; g <= NSRC; g++) begin : g_gw
            assign claim_vec[g] = claim_go && (arb_id == ID_W'(g));
            assign cmpl_vec[g]  = cmpl_go && (bus_wdata == DATA_W'(g));
            irq_gateway u_gw (
                .clk      (clk),
                .rst_n    (rst_n),
                .req      (src_req[g]),
                .claim    (claim_vec[g]),
                .complete (cmpl_vec[g]),
                .pending  (pend_vec[g]),
                .busy     (busy_vec[g])
            );
        end
    endgenerate

    irq_arbiter #(.NSRC(NSRC), .PRIO_W(PRIO_W), .ID_W(ID_W)) u_arb (
        .cand   (pend_vec & en_q),
        .prio   (prio_q),
        .thr    (thr_q),
        .win_id (arb_id),
        .any    (arb_any)
    );

    assign ext_irq = arb_any;

    always_comb begin
        rd_val = '0;
        if (in_prio) begin
            for (int k = 1; k <= NSRC; k++)
                if (pix == 10'(k)) rd_val[PRIO_W-1:0] = prio_q[k];
        end else if (at_pend) begin
            rd_val[NSRC:1] = pend_vec;
        end else if (at_en) begin
            rd_val[NSRC:1] = en_q;
        end else if (at_thr) begin
            rd_val[PRIO_W-1:0] = thr_q;
        end else if (at_claim) begin
            rd_val[ID_W-1:0] = arb_id;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prio_q    <= '0;
            en_q      <= '0;
            thr_q     <= '0;
            bus_rdata <= '0;
        end else begin
            if (bus_rd) bus_rdata <= rd_val;
            if (bus_wr) begin
                if (in_prio) begin
                    for (int k = 1; k <= NSRC; k++)
                        if (pix == 10'(k)) prio_q[k] <= bus_wdata[PRIO_W-1:0];
                end
                if (at_en)  en_q  <= bus_wdata[NSRC:1];
                if (at_thr) thr_q <= bus_wdata[PRIO_W-1:0];
            end
        end
    end
endmodule

// File: rtl/irq_hub_chk.sv
module irq_hub_chk
    import irq_hub_pkg::*;
#(
    parameter int NSRC   = 31,
    parameter int ADDR_W = 24,
    parameter int DATA_W = 32,
    parameter int ID_W   = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NSRC:1]     src_req,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              ext_irq,
    input logic [NSRC:1]     pend_vec,
    input logic [NSRC:1]     busy_vec,
    input logic [NSRC:1]     en_q,
    input logic [ID_W-1:0]   arb_id
);
    wire claim_rd = bus_rd && (bus_addr == OFF_CLAIM[ADDR_W-1:0]);

    p_pend_from_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend_vec & ~$past(pend_vec) & ~$past(src_req)) == '0));

    p_irq_has_source_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ext_irq |-> ((pend_vec & en_q) != '0));

    p_claim_win_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (claim_rd && ext_irq) |=> (bus_rdata != '0));

    p_claim_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (claim_rd && arb_id != '0) |=>
            (busy_vec[$past(arb_id)] && !pend_vec[$past(arb_id)]));

    p_no_repend_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend_vec & ~$past(pend_vec) & $past(busy_vec)) == '0));

    p_release_by_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(busy_vec) & ~busy_vec) != '0) |->
            ($past(bus_wr) && ($past(bus_addr) == OFF_CLAIM[ADDR_W-1:0])));

    p_empty_claim_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (claim_rd && !ext_irq) |=> (bus_rdata == '0));
endmodule

bind irq_hub irq_hub_chk #(
    .NSRC(NSRC), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ID_W(ID_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .src_req(src_req), .bus_addr(bus_addr),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_rdata(bus_rdata),
    .ext_irq(ext_irq), .pend_vec(pend_vec), .busy_vec(busy_vec),
    .en_q(en_q), .arb_id(arb_id)
);

// File: tb/sim_irq_hub.sv
`timescale 1ns/1ps
module sim_irq_hub;
    localparam logic [23:0] A_PEND = 24'h001000, A_EN = 24'h002000,
                            A_THR = 24'h200000, A_CLM = 24'h200004;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic [31:1] src_req = '0;
    logic [23:0] bus_addr = '0;
    logic        bus_rd = 1'b0, bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic        ext_irq;

    int vectors = 0, miscompares = 0;
    bit done = 1'b0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #4 clk = ~clk;

    irq_hub u0 (.clk(clk), .rst_n(rst_n), .src_req(src_req), .bus_addr(bus_addr),
                .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
                .bus_rdata(bus_rdata), .ext_irq(ext_irq));

    // Monitor: pops the expected value for each read the design serves.
    initial forever begin
        @(posedge clk);
        if (bus_rd) begin
            @(negedge clk);
            vectors++;
            if (bus_rdata !== exp_q[0]) begin
                miscompares++;
                $display("FAIL %s: rdata=%h expected=%h", tag_q[0], bus_rdata, exp_q[0]);
            end
            void'(exp_q.pop_front());
            void'(tag_q.pop_front());
        end
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rd(logic [23:0] a, logic [31:0] e, string t);
        @(negedge clk);
        exp_q.push_back(e); tag_q.push_back(t);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic wr(logic [23:0] a, logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic chk_irq(logic e, string t);
        vectors++;
        if (ext_irq !== e) begin
            miscompares++;
            $display("FAIL %s: ext_irq=%b expected=%b", t, ext_irq, e);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    endtask

    initial begin
        #(8 * 20000);
        miscompares++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        tick(3); rst_n = 1'b1; tick(1);
        // R1 reset state
        chk_irq(1'b0, "R1 irq");
        rd(A_PEND, 0, "R1 pend"); rd(24'h14, 0, "R1 prio5");
        rd(A_THR, 0, "R1 thr"); rd(A_EN, 0, "R1 en");
        // R10 readback, R9 ID 0 priority
        wr(24'h0C, 7);  rd(24'h0C, 7, "R10 prio3");
        wr(24'h10, 32'hFF); rd(24'h10, 7, "R10 prio4 masked");
        wr(A_EN, 32'hFFFF_FFFF); rd(A_EN, 32'hFFFF_FFFE, "R10 en");
        wr(24'h00, 5); rd(24'h00, 0, "R9 prio0");
        // R2 latched pulse
        @(negedge clk); src_req[3] = 1'b1;
        @(negedge clk); src_req[3] = 1'b0;
        tick(1);
        rd(A_PEND, 32'h8, "R2 latched");
        chk_irq(1'b1, "R3 eligible");
        // R4 strict threshold, R8 empty claim
        wr(A_THR, 7); chk_irq(1'b0, "R4 equal masked");
        rd(A_CLM, 0, "R8 empty claim");
        rd(A_PEND, 32'h8, "R8 no change");
        wr(A_THR, 6); chk_irq(1'b1, "R4 above");
        // R9 pending write ignored, unmapped reads
        wr(A_PEND, 0); rd(A_PEND, 32'h8, "R9 pend write");
        rd(24'h003000, 0, "R9 unmapped"); rd(24'h200008, 0, "R9 unmapped2");
        // R5 ordering
        wr(A_THR, 0); wr(24'h28, 7); wr(24'h08, 5);
        @(negedge clk); src_req[2] = 1'b1; src_req[4] = 1'b1; src_req[10] = 1'b1;
        tick(1);
        rd(A_CLM, 3, "R5 tie lowest");
        rd(A_CLM, 4, "R5 next");
        rd(A_CLM, 10, "R5 third");
        rd(A_CLM, 2, "R5 lower prio");
        rd(A_CLM, 0, "R8 drained");
        // R6 no re-pend while busy
        tick(2);
        rd(A_PEND, 0, "R6 held requests");
        chk_irq(1'b0, "R6 irq low");
        // R7 complete
        wr(A_CLM, 4); tick(1);
        rd(A_PEND, 32'h10, "R7 re-pend");
        wr(A_CLM, 4); tick(1);
        rd(A_CLM, 4, "R7 stray complete ignored");
        wr(A_CLM, 5); tick(1);
        rd(A_PEND, 0, "R7 idle complete ignored");
        @(negedge clk); src_req[10] = 1'b0;
        wr(A_CLM, 10); tick(1);
        rd(A_PEND, 0, "R7 released no request");
        // R4 priority zero, R3 enable gating
        wr(24'h08, 0); wr(A_CLM, 2); tick(1);
        rd(A_PEND, 32'h4, "R4 prio0 pending");
        chk_irq(1'b0, "R4 prio0 masked");
        wr(24'h08, 3); chk_irq(1'b1, "R3 prio set");
        wr(A_EN, 32'hFFFF_FFFB); chk_irq(1'b0, "R3 disabled");
        wr(A_EN, 32'hFFFF_FFFF); chk_irq(1'b1, "R3 reenabled");
        rd(A_CLM, 2, "R5 claim 2");
        tick(3);
        finish_run();
    end
endmodule